// File: doc/BRIEF.md
# SPI Serial Memory Slave Front-End

This block is the serial-bus side of a byte-addressed memory of 1M × 8. It oversamples chip select, serial clock and serial data-in with a fast system clock. It decodes one command byte per chip-select frame and collects a 24-bit address. It then moves data bytes between the serial line and a single-port synchronous memory array, advancing the address after every byte. Writes take effect as soon as the eighth bit of a byte arrives, so the host never polls for completion.

A write-enable latch gates write commands. A separate permission input from a protection unit can still veto each array store. The serial output is driven only while a read is returning data. At every other time the output-enable is low, so the pad stays in high impedance.

Top module: `spi_mem_slave`

## Requirements
- R1: Serial data-in is sampled on rising serial-clock edges and serial data-out changes on falling edges, most significant bit first. Both clock-idle-low (mode 0) and clock-idle-high (mode 3) framing work.
- R2: The first byte after chip select falls is the command. 0x03 reads, 0x02 writes, 0x06 sets the write-enable latch and 0x04 clears it. Any other value is ignored together with the rest of its frame.
- R3: A read or write command is followed by three address bytes, most significant first. The upper four bits are ignored and the lower 20 bits select the byte location.
- R4: Only one command is decoded per chip-select low period. Bytes after a non-data command have no effect.
- R5: `spi_miso_oe` is high only in the data phase of a read. It is low while chip select is high, in the cycle after chip select rises, and throughout write and control frames.
- R6: Each complete write data byte causes exactly one `mem_we` strobe, with no delay beyond synchronisation. Reads issue `mem_re` and take `mem_rdata` one clock later.
- R7: A write command is ignored unless the write-enable latch is set. The latch clears when chip select rises at the end of a frame that accepted a write command.
- R8: While `wr_allow` is low when a write byte completes, no array store is made. The address still advances.
- R9: The address increments after every data byte in both directions and wraps from 0xFFFFF to 0x00000.
- R10: A byte cut short by chip select rising is discarded and causes no store.
- R11: The serial clock may stop for any time mid-byte without losing the frame state.
- R12: After reset the output-enable, `mem_we` and `mem_re` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Drive enable for the serial output pad |
| mem_addr | output | 20 | Array byte address |
| mem_wdata | output | 8 | Array write data |
| mem_we | output | 1 | Array write strobe, one clock per byte |
| mem_re | output | 1 | Array read strobe; data is expected one clock later |
| mem_rdata | input | 8 | Array read data |
| wr_allow | input | 1 | Write permission from the protection unit |

## Verification
Reads in both clock polarities are compared against an arithmetic fill pattern. A wrong bit order or edge choice shows up as garbled bytes. A wrong address assembly shows up as the wrong pattern offset. Write bursts are read back across the 0xFFFFF wrap and with a top nibble set in the address. Writes are also tried with the latch cleared, cleared again by the control command, cleared by a previous write frame and vetoed by the permission input, and each of these must leave the pattern intact. A truncated byte, a long clock stall and a sweep of every command value then separate a correct decoder from one that acts on stray or partial input.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
   typedef enum logic [2:0] {
      PH_IDLE, PH_CMD, PH_ADDR, PH_WDATA, PH_RDATA, PH_SKIP
   } phase_e;

   localparam logic [7:0] CMD_READ  = 8'h03;
   localparam logic [7:0] CMD_WRITE = 8'h02;
   localparam logic [7:0] CMD_WEN   = 8'h06;
   localparam logic [7:0] CMD_WDIS  = 8'h04;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
   parameter int          W       = 3,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spi_sync needs at least two stages");
   end

   logic [W-1:0] st [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     st[s] <= RST_VAL;
         else if (s == 0) st[s] <= d;
         else            st[s] <= st[(s == 0) ? 0 : s-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/spi_rx_byte.sv
module spi_rx_byte #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         sample,
   input  logic         din,
   output logic         done,
   output logic [W-1:0] data
);
   localparam int CW = $clog2(W);

   if (W < 2) begin : g_bad_width
      $error("spi_rx_byte width too small");
   end

   logic [CW-1:0] cnt;
   logic [W-2:0]  sh;

   assign done = sample && (cnt == CW'(W-1));
   assign data = {sh, din};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         sh  <= '0;
      end else if (clear) begin
         cnt <= '0;
      end else if (sample) begin
         sh  <= data[W-2:0];
         cnt <= done ? '0 : cnt + 1'b1;
      end
   end

   // R10
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> cnt == '0);
endmodule

// File: rtl/spi_tx_byte.sv
module spi_tx_byte #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_data,
   input  logic         shift,
   output logic         bit_out,
   output logic         last
);
   localparam int CW = $clog2(W);

   logic [CW-1:0] cnt;
   logic [W-1:0]  sh;

   assign last = shift && (cnt == CW'(W-1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         sh      <= '0;
         bit_out <= 1'b0;
      end else if (load) begin
         sh  <= load_data;
         cnt <= '0;
      end else if (shift) begin
         bit_out <= sh[W-1];
         sh      <= {sh[W-2:0], 1'b0};
         cnt     <= last ? '0 : cnt + 1'b1;
      end
   end
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
   import spi_mem_pkg::*;
#(
   parameter int ADDR_W     = 20,
   parameter int ADDR_BYTES = 3,
   parameter int DATA_W     = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_cs_n,
   input  logic              spi_sck,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic              spi_miso_oe,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   output logic              mem_re,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              wr_allow
);
   localparam int ACC_W = ADDR_W - DATA_W;
   localparam int ACW   = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

   if (DATA_W != 8) begin : g_bad_data
      $error("command decoding needs 8-bit bytes");
   end
   if (ADDR_W <= DATA_W || ADDR_W > ADDR_BYTES * DATA_W) begin : g_bad_addr
      $error("address width does not fit the address bytes");
   end

   logic cs_s, sck_s, mosi_s, cs_q, sck_q;
   logic cs_rise, cs_fall, sck_rise, sck_fall;

   spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({spi_cs_n, spi_sck, spi_mosi}),
      .q({cs_s, sck_s, mosi_s})
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q  <= 1'b1;
         sck_q <= 1'b0;
      end else begin
         cs_q  <= cs_s;
         sck_q <= sck_s;
      end
   end

   assign cs_rise  =  cs_s & ~cs_q;
   assign cs_fall  = ~cs_s &  cs_q;
   assign sck_rise =  sck_s & ~sck_q & ~cs_s;
   assign sck_fall = ~sck_s &  sck_q & ~cs_s;

   phase_e            phase;
   logic              rx_done;
   logic [DATA_W-1:0] rx_data;
   logic              tx_last, tx_bit;
   logic              wel, is_rd, wr_frame;
   logic              we_q, re_q, ld_q, step_q;
   logic [ACW-1:0]    addr_cnt;
   logic [ACC_W-1:0]  addr_acc;
   logic [ADDR_W-1:0] addr;
   logic [DATA_W-1:0] wdata;

   spi_rx_byte #(.W(DATA_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .clear(cs_fall),
      .sample(sck_rise && phase != PH_IDLE), .din(mosi_s),
      .done(rx_done), .data(rx_data)
   );

   spi_tx_byte #(.W(DATA_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .load(ld_q), .load_data(mem_rdata),
      .shift(sck_fall && phase == PH_RDATA),
      .bit_out(tx_bit), .last(tx_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         wel      <= 1'b0;
         is_rd    <= 1'b0;
         wr_frame <= 1'b0;
         addr_cnt <= '0;
         addr_acc <= '0;
         addr     <= '0;
         wdata    <= '0;
         we_q     <= 1'b0;
         re_q     <= 1'b0;
         ld_q     <= 1'b0;
         step_q   <= 1'b0;
      end else begin
         we_q   <= 1'b0;
         re_q   <= 1'b0;
         step_q <= 1'b0;
         ld_q   <= re_q;
         if (step_q || ld_q) addr <= addr + 1'b1;
         if (cs_rise) begin
            phase    <= PH_IDLE;
            wr_frame <= 1'b0;
            if (wr_frame) wel <= 1'b0;
         end else if (cs_fall) begin
            phase    <= PH_CMD;
            addr_cnt <= '0;
         end else if (rx_done) begin
            case (phase)
               PH_CMD: begin
                  phase <= PH_SKIP;
                  if (rx_data == CMD_READ) begin
                     is_rd <= 1'b1;
                     phase <= PH_ADDR;
                  end else if (rx_data == CMD_WRITE && wel) begin
                     is_rd    <= 1'b0;
                     wr_frame <= 1'b1;
                     phase    <= PH_ADDR;
                  end else if (rx_data == CMD_WEN) begin
                     wel <= 1'b1;
                  end else if (rx_data == CMD_WDIS) begin
                     wel <= 1'b0;
                  end
               end
               PH_ADDR: begin
                  addr_acc <= ACC_W'({addr_acc, rx_data});
                  addr_cnt <= addr_cnt + 1'b1;
                  if (addr_cnt == ACW'(ADDR_BYTES-1)) begin
                     addr  <= ADDR_W'({addr_acc, rx_data});
                     phase <= is_rd ? PH_RDATA : PH_WDATA;
                     re_q  <= is_rd;
                  end
               end
               PH_WDATA: begin
                  we_q   <= wr_allow;
                  step_q <= 1'b1;
                  wdata  <= rx_data;
               end
               default: ;
            endcase
         end else if (phase == PH_RDATA && tx_last) begin
            re_q <= 1'b1;
         end
      end
   end

   assign spi_miso    = tx_bit;
   assign spi_miso_oe = (phase == PH_RDATA);
   assign mem_addr    = addr;
   assign mem_wdata   = wdata;
   assign mem_we      = we_q;
   assign mem_re      = re_q;

   // R5
   oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_rise |=> !spi_miso_oe);
   // R6
   one_port_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));
   // R7
   latch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> wel);
   // R8
   permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> $past(wr_allow));
   // R9
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> mem_addr == $past(mem_addr) + 1'b1);
endmodule

// File: tb/test_spi_mem_slave.sv
module test_spi_mem_slave;
   localparam int CLK_P = 10;
   localparam int HALF  = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wr_allow = 1'b1;
   logic miso, miso_oe, mem_we, mem_re;
   logic [19:0] mem_addr;
   logic [7:0]  mem_wdata, mem_rdata;

   int checks = 0, errors = 0, we_cnt = 0, oe_cnt = 0;
   bit done = 1'b0;
   logic [7:0] ram   [4096];
   logic [7:0] exp_m [4096];

   always #(CLK_P/2) clk = ~clk;

   spi_mem_slave i_spi_mem_slave (
      .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck),
      .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(miso_oe),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
      .mem_re(mem_re), .mem_rdata(mem_rdata), .wr_allow(wr_allow)
   );

   always @(posedge clk) begin
      if (mem_we) begin
         ram[mem_addr[11:0]] <= mem_wdata;
         we_cnt <= we_cnt + 1;
      end
      if (mem_re) mem_rdata <= ram[mem_addr[11:0]];
      if (miso_oe) oe_cnt <= oe_cnt + 1;
   end

   function automatic logic [7:0] pat(input int i);
      return 8'((i * 7 + (i >> 5)) ^ 8'h5A);
   endfunction

   function automatic int loc(input logic [23:0] a, input int k);
      logic [19:0] s;
      s = a[19:0] + 20'(k);
      return int'(s[11:0]);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic xfer(input logic [7:0] tx, input int nbits, input int pause,
                       output logic [7:0] rx);
      rx = '0;
      for (int b = 7; b >= 8 - nbits; b--) begin
         @(negedge clk) sck = 1'b0; mosi = tx[b];
         repeat (HALF) @(negedge clk);
         rx[b] = miso;
         sck = 1'b1;
         repeat (HALF) @(negedge clk);
         if (b == 4) repeat (pause) @(negedge clk);
      end
   endtask

   task automatic fstart(input bit m3);
      @(negedge clk) sck = m3;
      repeat (4) @(negedge clk);
      cs_n = 1'b0;
      we_cnt = 0; oe_cnt = 0;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic fend(input bit m3);
      if (!m3) begin
         @(negedge clk) sck = 1'b0;
         repeat (HALF) @(negedge clk);
      end
      cs_n = 1'b1;
      repeat (2 * HALF) @(negedge clk);
   endtask

   task automatic send_hdr(input logic [7:0] op, input logic [23:0] a);
      logic [7:0] r;
      xfer(op, 8, 0, r);
      xfer(a[23:16], 8, 0, r);
      xfer(a[15:8], 8, 0, r);
      xfer(a[7:0], 8, 0, r);
   endtask

   task automatic cmd(input logic [7:0] op);
      logic [7:0] r;
      fstart(1'b0);
      xfer(op, 8, 0, r);
      fend(1'b0);
   endtask

   task automatic wr(input logic [23:0] a, input int n, input logic [7:0] base,
                     input bit m3, input bit stores, input int pause);
      logic [7:0] r;
      fstart(m3);
      send_hdr(8'h02, a);
      for (int k = 0; k < n; k++) begin
         xfer(8'(base + 8'(k * 13)), 8, pause, r);
         if (stores) exp_m[loc(a, k)] = 8'(base + 8'(k * 13));
      end
      fend(m3);
   endtask

   task automatic rd(input logic [23:0] a, input int n, input bit m3, input string req);
      logic [7:0] r;
      fstart(m3);
      send_hdr(8'h03, a);
      for (int k = 0; k < n; k++) begin
         xfer(8'h00, 8, 0, r);
         chk(r == exp_m[loc(a, k)], req, r, exp_m[loc(a, k)]);
      end
      fend(m3);
      chk(miso_oe == 1'b0, "R5 idle after read", miso_oe, 0);
   endtask

   initial begin
      for (int i = 0; i < 4096; i++) begin
         ram[i] = pat(i);
         exp_m[i] = pat(i);
      end
   end

   initial begin
      logic [7:0] r;
      repeat (5) @(negedge clk);
      chk(miso_oe == 1'b0 && mem_we == 1'b0 && mem_re == 1'b0, "R12 reset", {miso_oe, mem_we, mem_re}, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(miso_oe == 1'b0 && mem_we == 1'b0 && mem_re == 1'b0, "R12 after reset", {miso_oe, mem_we, mem_re}, 0);

      rd(24'h000010, 8, 1'b0, "R1 mode0 read");
      chk(oe_cnt > 0, "R5 driven in read", oe_cnt, 1);
      rd(24'h000020, 8, 1'b1, "R1 mode3 read");

      wr(24'h000100, 4, 8'h11, 1'b0, 1'b0, 0);
      chk(we_cnt == 0, "R7 write without latch", we_cnt, 0);
      rd(24'h000100, 4, 1'b0, "R7 data untouched");

      cmd(8'h06);
      wr(24'hF00200, 4, 8'h80, 1'b1, 1'b1, 0);
      chk(we_cnt == 4, "R6 one store per byte", we_cnt, 4);
      chk(oe_cnt == 0, "R5 quiet during write", oe_cnt, 0);
      rd(24'h000200, 4, 1'b1, "R3 top nibble ignored");

      wr(24'h000200, 2, 8'h33, 1'b0, 1'b0, 0);
      chk(we_cnt == 0, "R7 latch cleared after write", we_cnt, 0);

      cmd(8'h06); cmd(8'h04);
      wr(24'h000210, 2, 8'h44, 1'b0, 1'b0, 0);
      chk(we_cnt == 0, "R2 disable command", we_cnt, 0);

      fstart(1'b0);
      xfer(8'h05, 8, 0, r); xfer(8'h06, 8, 0, r);
      fend(1'b0);
      wr(24'h000220, 2, 8'h55, 1'b0, 1'b0, 0);
      chk(we_cnt == 0, "R4 second command ignored", we_cnt, 0);

      cmd(8'h06);
      wr(24'h0FFFFE, 4, 8'hC1, 1'b0, 1'b1, 0);
      chk(we_cnt == 4, "R9 stores across wrap", we_cnt, 4);
      rd(24'h0FFFFE, 4, 1'b1, "R9 wrap read");

      cmd(8'h06);
      fstart(1'b0);
      send_hdr(8'h02, 24'h000300);
      xfer(8'h9C, 8, 0, r); exp_m[12'h300] = 8'h9C;
      xfer(8'hE7, 5, 0, r);
      fend(1'b0);
      chk(we_cnt == 1, "R10 partial byte dropped", we_cnt, 1);
      rd(24'h000300, 2, 1'b0, "R10 partial readback");

      cmd(8'h06);
      wr_allow = 1'b0;
      wr(24'h000400, 3, 8'h21, 1'b0, 1'b0, 0);
      chk(we_cnt == 0, "R8 permission veto", we_cnt, 0);
      wr_allow = 1'b1;
      wr(24'h000400, 3, 8'h21, 1'b0, 1'b0, 0);
      chk(we_cnt == 0, "R7 latch cleared after vetoed write", we_cnt, 0);
      rd(24'h000400, 3, 1'b0, "R8 data untouched");

      cmd(8'h06);
      wr(24'h000500, 2, 8'h6D, 1'b1, 1'b1, 300);
      chk(we_cnt == 2, "R11 stores after stall", we_cnt, 2);
      rd(24'h000500, 2, 1'b0, "R11 stall readback");

      for (int op = 0; op < 256; op++) begin
         if (op != 3) begin
            fstart(1'b0);
            xfer(8'(op), 8, 0, r);
            xfer(8'h00, 8, 0, r);
            fend(1'b0);
            chk(oe_cnt == 0 && we_cnt == 0, "R2 command sweep", op, 0);
         end
      end
      rd(24'h000010, 4, 1'b0, "R2 array intact after sweep");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule